// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns the 6-bit operand field of a 16-bit instruction into a resolved operand. It tells the instruction controller where the operand lives and what its current value is. The field can name one of eight general registers, a memory word addressed through a register, through a register plus an offset word or through the stack pointer, one of the three special registers (stack pointer, program counter, overflow), or an immediate. An immediate is either carried inline in the code itself or taken from the word after the instruction.

The controller pulses `start_i` with the code, the current SP, PC and overflow values, and the register file value selected by `reg_idx_o`. The block then issues whatever memory reads the mode needs on a request/valid read port. First comes an optional fetch of the word at PC, which the controller accounts for through `pc_inc_o`. Then, for memory modes, comes a read of the operand itself. When the result is ready the block pulses `done_o` and holds the resolved operand until the next start. Stack modes report the new stack pointer with `sp_upd_o`. Literal operands are flagged, and a later write-back request aimed at a literal produces no write at all.

Top module: `opnd_resolver`

## Requirements
- R1: Codes 0x00 to 0x07 select general register code[2:0] (index 0 = A through 7 = J). The value is that register's content, ea_o is the index, there is no memory access, and is_mem_o = 0.
- R2: Codes 0x08 to 0x0F use register code[2:0] as the memory address. ea_o is the register content, value_o is the memory word there, and is_mem_o = 1.
- R3: Codes 0x10 to 0x17 read the word at PC, then address memory at that word plus register code[2:0], modulo 2^16. value_o is the memory word there.
- R4: Code 0x18 (pop) addresses memory at SP and, with done_o, pulses sp_upd_o with sp_nxt_o = SP + 1 modulo 2^16.
- R5: Code 0x19 (peek) addresses memory at SP and never pulses sp_upd_o.
- R6: Code 0x1A (push) addresses memory at SP - 1 modulo 2^16 and, with done_o, pulses sp_upd_o with sp_nxt_o = SP - 1.
- R7: Codes 0x1B, 0x1C and 0x1D return the SP, PC and overflow values sampled at start, with no memory access and is_mem_o = 0.
- R8: Code 0x1E reads the word at PC and uses it as the memory address. value_o is the memory word there.
- R9: Code 0x1F reads the word at PC and returns it as the value, with no further memory access.
- R10: Codes 0x20 to 0x3F return code - 0x20 with no memory access.
- R11: is_lit_o = 1 exactly for codes 0x1F and above, and a write-back request to such an operand gives wr_kind_o = 0 (no write).
- R12: xcyc_o = 1, and pc_inc_o pulses exactly once, for codes 0x10 to 0x17, 0x1E and 0x1F. For every other code xcyc_o = 0 and pc_inc_o stays low.
- R13: done_o is a one-cycle pulse after the last memory response. start_i is ignored while an operand is being resolved, the result holds until the next start, and reset leaves done_o, mem_req_o, pc_inc_o and sp_upd_o low.
- R14: With wb_i high while idle after a resolution, wr_kind_o gives 1 for a register, 2 for memory, 3 for SP, 4 for PC and 5 for overflow. In each case wr_addr_o = ea_o and wr_data_o = wb_data_i. With wb_i low, wr_kind_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving code_i |
| code_i | input | 6 | Operand field |
| reg_idx_o | output | 3 | Register file read index (code_i[2:0]) |
| reg_data_i | input | 16 | Register file read data |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Current program counter |
| ov_i | input | 16 | Current overflow register |
| mem_req_o | output | 1 | Memory read request, held until valid |
| mem_addr_o | output | 16 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |
| pc_inc_o | output | 1 | Extra word consumed, PC must advance |
| sp_upd_o | output | 1 | Stack pointer must take sp_nxt_o |
| sp_nxt_o | output | 16 | New stack pointer |
| done_o | output | 1 | Resolution complete pulse |
| ea_o | output | 16 | Effective address or register index |
| value_o | output | 16 | Operand value |
| is_mem_o | output | 1 | Operand is in memory |
| is_lit_o | output | 1 | Operand is literal, writes suppressed |
| xcyc_o | output | 1 | Operand cost one extra word cycle |
| wb_i | input | 1 | Write-back request to resolved operand |
| wb_data_i | input | 16 | Write-back data |
| wr_kind_o | output | 3 | Write target class |
| wr_addr_o | output | 16 | Write target address or index |
| wr_data_o | output | 16 | Write data |

## Verification
A wrong stored mode shows up at the first `done_o` of that operand. It appears as a wrong value, a wrong flag, or an extra or missing memory request and `pc_inc_o` pulse, because each mode differs from its neighbours in at least one of these. A corrupted sequencer state shows either as a `done_o` that never arrives or as a request address that changes before its response. Both are visible within a few cycles of the memory latency. A stale stack or write-back decision becomes visible on the same cycle as `done_o` or as the write-back request.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
    localparam int OPC_W  = 6;
    localparam int RIDX_W = 3;

    typedef enum logic [3:0] {
        MK_REG, MK_IND, MK_IDX, MK_POP, MK_PEEK, MK_PUSH,
        MK_SP, MK_PC, MK_OV, MK_NWIND, MK_NWLIT, MK_SLIT
    } mkind_e;

    typedef struct packed {
        mkind_e kind;
        logic   nw;   // needs extra word at PC
        logic   rd;   // needs operand read from memory
        logic   mem;  // operand lives in memory
        logic   lit;  // operand is a literal
    } mdesc_t;

    typedef enum logic [2:0] {
        WK_NONE = 3'd0, WK_REG = 3'd1, WK_MEM = 3'd2,
        WK_SP   = 3'd3, WK_PC  = 3'd4, WK_OV  = 3'd5
    } wkind_e;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_READ, S_FIN} st_e;
endpackage

// File: rtl/opnd_mode_lut.sv
module opnd_mode_lut
    import opnd_pkg::*;
(
    input  logic [OPC_W-1:0] code_i,
    output mdesc_t           desc_o
);
    always_comb begin
        desc_o = '{kind: MK_REG, nw: 1'b0, rd: 1'b0, mem: 1'b0, lit: 1'b0};
        if (code_i[5]) begin
            desc_o.kind = MK_SLIT;
            desc_o.lit  = 1'b1;
        end else begin
            unique case (code_i[4:3])
                2'd0: desc_o.kind = MK_REG;
                2'd1: begin
                    desc_o.kind = MK_IND;
                    desc_o.rd   = 1'b1;
                    desc_o.mem  = 1'b1;
                end
                2'd2: begin
                    desc_o.kind = MK_IDX;
                    desc_o.nw   = 1'b1;
                    desc_o.rd   = 1'b1;
                    desc_o.mem  = 1'b1;
                end
                default: begin
                    unique case (code_i[2:0])
                        3'd0: begin desc_o.kind = MK_POP;  desc_o.rd = 1'b1; desc_o.mem = 1'b1; end
                        3'd1: begin desc_o.kind = MK_PEEK; desc_o.rd = 1'b1; desc_o.mem = 1'b1; end
                        3'd2: begin desc_o.kind = MK_PUSH; desc_o.rd = 1'b1; desc_o.mem = 1'b1; end
                        3'd3: desc_o.kind = MK_SP;
                        3'd4: desc_o.kind = MK_PC;
                        3'd5: desc_o.kind = MK_OV;
                        3'd6: begin
                            desc_o.kind = MK_NWIND;
                            desc_o.nw   = 1'b1;
                            desc_o.rd   = 1'b1;
                            desc_o.mem  = 1'b1;
                        end
                        default: begin
                            desc_o.kind = MK_NWLIT;
                            desc_o.nw   = 1'b1;
                            desc_o.lit  = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd_wr_route.sv
module opnd_wr_route
    import opnd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          en_i,
    input  mdesc_t        desc_i,
    input  logic [DW-1:0] ea_i,
    input  logic [DW-1:0] data_i,
    output wkind_e        kind_o,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    always_comb begin
        kind_o = WK_NONE;
        addr_o = ea_i;
        data_o = data_i;
        if (en_i && !desc_i.lit) begin
            if (desc_i.mem) begin
                kind_o = WK_MEM;
            end else begin
                unique case (desc_i.kind)
                    MK_REG:  kind_o = WK_REG;
                    MK_SP:   kind_o = WK_SP;
                    MK_PC:   kind_o = WK_PC;
                    MK_OV:   kind_o = WK_OV;
                    default: kind_o = WK_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OPC_W-1:0]  code_i,
    output logic [RIDX_W-1:0] reg_idx_o,
    input  logic [DW-1:0]     reg_data_i,
    input  logic [DW-1:0]     sp_i,
    input  logic [DW-1:0]     pc_i,
    input  logic [DW-1:0]     ov_i,
    output logic              mem_req_o,
    output logic [DW-1:0]     mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              pc_inc_o,
    output logic              sp_upd_o,
    output logic [DW-1:0]     sp_nxt_o,
    output logic              done_o,
    output logic [DW-1:0]     ea_o,
    output logic [DW-1:0]     value_o,
    output logic              is_mem_o,
    output logic              is_lit_o,
    output logic              xcyc_o,
    input  logic              wb_i,
    input  logic [DW-1:0]     wb_data_i,
    output logic [2:0]        wr_kind_o,
    output logic [DW-1:0]     wr_addr_o,
    output logic [DW-1:0]     wr_data_o
);
    localparam int SLIT_W = OPC_W - 1;

    typedef struct packed {
        st_e           st;
        mdesc_t        md;
        logic [DW-1:0] regv;
        logic [DW-1:0] pc;
        logic [DW-1:0] ea;
        logic [DW-1:0] val;
        logic [DW-1:0] spn;
        logic          have;
    } ctx_t;

    ctx_t   ctx_d, ctx_q;
    mdesc_t desc_in;
    wkind_e wk;

    opnd_mode_lut u_lut (
        .code_i (code_i),
        .desc_o (desc_in)
    );

    assign reg_idx_o = code_i[RIDX_W-1:0];

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctx_d.md   = desc_in;
                    ctx_d.regv = reg_data_i;
                    ctx_d.pc   = pc_i;
                    ctx_d.spn  = sp_i;
                    ctx_d.have = 1'b0;
                    ctx_d.ea   = '0;
                    ctx_d.val  = '0;
                    unique case (desc_in.kind)
                        MK_REG: begin
                            ctx_d.ea  = DW'(code_i[RIDX_W-1:0]);
                            ctx_d.val = reg_data_i;
                        end
                        MK_IND:  ctx_d.ea = reg_data_i;
                        MK_POP: begin
                            ctx_d.ea  = sp_i;
                            ctx_d.spn = sp_i + DW'(1);
                        end
                        MK_PEEK: ctx_d.ea = sp_i;
                        MK_PUSH: begin
                            ctx_d.ea  = sp_i - DW'(1);
                            ctx_d.spn = sp_i - DW'(1);
                        end
                        MK_SP:   ctx_d.val = sp_i;
                        MK_PC:   ctx_d.val = pc_i;
                        MK_OV:   ctx_d.val = ov_i;
                        MK_SLIT: ctx_d.val = DW'(code_i[SLIT_W-1:0]);
                        default: ;
                    endcase
                    if (desc_in.nw)      ctx_d.st = S_FETCH;
                    else if (desc_in.rd) ctx_d.st = S_READ;
                    else                 ctx_d.st = S_FIN;
                end
            end
            S_FETCH: begin
                if (mem_rvalid_i) begin
                    unique case (ctx_q.md.kind)
                        MK_IDX: begin
                            ctx_d.ea = mem_rdata_i + ctx_q.regv;
                            ctx_d.st = S_READ;
                        end
                        MK_NWIND: begin
                            ctx_d.ea = mem_rdata_i;
                            ctx_d.st = S_READ;
                        end
                        default: begin
                            ctx_d.val = mem_rdata_i;
                            ctx_d.st  = S_FIN;
                        end
                    endcase
                end
            end
            S_READ: begin
                if (mem_rvalid_i) begin
                    ctx_d.val = mem_rdata_i;
                    ctx_d.st  = S_FIN;
                end
            end
            default: begin
                ctx_d.have = 1'b1;
                ctx_d.st   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, md: '{kind: MK_REG, nw: 1'b0, rd: 1'b0, mem: 1'b0, lit: 1'b0},
                       default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req_o  = (ctx_q.st == S_FETCH) || (ctx_q.st == S_READ);
    assign mem_addr_o = (ctx_q.st == S_FETCH) ? ctx_q.pc : ctx_q.ea;
    assign pc_inc_o   = (ctx_q.st == S_FETCH) && mem_rvalid_i;
    assign done_o     = (ctx_q.st == S_FIN);
    assign sp_upd_o   = done_o && ((ctx_q.md.kind == MK_POP) || (ctx_q.md.kind == MK_PUSH));
    assign sp_nxt_o   = ctx_q.spn;
    assign ea_o       = ctx_q.ea;
    assign value_o    = ctx_q.val;
    assign is_mem_o   = ctx_q.md.mem;
    assign is_lit_o   = ctx_q.md.lit;
    assign xcyc_o     = ctx_q.md.nw;

    opnd_wr_route #(.DW(DW)) u_route (
        .en_i   (wb_i && (ctx_q.st == S_IDLE) && ctx_q.have),
        .desc_i (ctx_q.md),
        .ea_i   (ctx_q.ea),
        .data_i (wb_data_i),
        .kind_o (wk),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o)
    );
    assign wr_kind_o = wk;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R13
    AST_LIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_lit_o |-> (wr_kind_o == 3'd0)); // R11
    AST_PCINC_XCYC: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |-> xcyc_o); // R12
    AST_PCINC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |=> !pc_inc_o); // R12
    AST_SPUPD_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        sp_upd_o |-> (is_mem_o && done_o)); // R4
    AST_LIT_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(is_lit_o && is_mem_o)); // R10
endmodule

// File: tb/opnd_resolver_bench.sv
module opnd_resolver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  code_i = '0;
    logic [2:0]  reg_idx_o;
    logic [15:0] reg_data_i;
    logic [15:0] sp_i = '0, pc_i = '0, ov_i = 16'h00C5;
    logic        mem_req_o, mem_rvalid_i = 1'b0;
    logic [15:0] mem_addr_o, mem_rdata_i = '0;
    logic        pc_inc_o, sp_upd_o, done_o, is_mem_o, is_lit_o, xcyc_o;
    logic [15:0] sp_nxt_o, ea_o, value_o;
    logic        wb_i = 1'b0;
    logic [15:0] wb_data_i = '0;
    logic [2:0]  wr_kind_o;
    logic [15:0] wr_addr_o, wr_data_o;

    int checks = 0, fails = 0, cyc = 0, lat = 0, mcnt = 0;
    int n_pcinc = 0, n_resp = 0, n_done = 0;
    logic [15:0] rf [8];

    opnd_resolver u_opnd_resolver (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mfn(input logic [15:0] a);
        return a * 16'h9E37 + 16'h1234;
    endfunction

    assign reg_data_i = rf[reg_idx_o];

    always @(posedge clk) begin
        if (mem_req_o && !mem_rvalid_i) begin
            if (mcnt >= lat) begin
                mem_rvalid_i <= 1'b1;
                mem_rdata_i  <= mfn(mem_addr_o);
                mcnt <= 0;
            end else mcnt <= mcnt + 1;
        end else mem_rvalid_i <= 1'b0;
        if (pc_inc_o) n_pcinc <= n_pcinc + 1;
        if (mem_rvalid_i) n_resp <= n_resp + 1;
        if (done_o) n_done <= n_done + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog R13 act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // code, sp, pc, latency, expected is_mem, is_lit, xcyc
    localparam logic [42:0] VEC [NV] = '{
        {6'h00, 16'h1111, 16'h0100, 2'd0, 3'b000},  // R1 A
        {6'h07, 16'h1111, 16'h0100, 2'd1, 3'b000},  // R1 J
        {6'h09, 16'h1111, 16'h0100, 2'd0, 3'b100},  // R2 [B]
        {6'h0F, 16'h1111, 16'h0100, 2'd2, 3'b100},  // R2 [J]
        {6'h12, 16'h1111, 16'h0200, 2'd1, 3'b101},  // R3 [nw+C]
        {6'h17, 16'h1111, 16'h4000, 2'd0, 3'b101},  // R3 [nw+J] wraps
        {6'h18, 16'h2000, 16'h0100, 2'd0, 3'b100},  // R4 pop
        {6'h19, 16'h2000, 16'h0100, 2'd1, 3'b100},  // R5 peek
        {6'h1A, 16'h0000, 16'h0100, 2'd0, 3'b100},  // R6 push wraps
        {6'h1B, 16'h3456, 16'h0100, 2'd0, 3'b000},  // R7 SP
        {6'h1C, 16'h3456, 16'h0ABC, 2'd0, 3'b000},  // R7 PC
        {6'h1D, 16'h3456, 16'h0100, 2'd0, 3'b000},  // R7 O
        {6'h1E, 16'h1111, 16'h0300, 2'd2, 3'b101},  // R8
        {6'h1F, 16'h1111, 16'h0400, 2'd3, 3'b011},  // R9
        {6'h20, 16'h1111, 16'h0100, 2'd0, 3'b010},  // R10 low
        {6'h3F, 16'h1111, 16'h0100, 2'd0, 3'b010},  // R10 high
        {6'h18, 16'hFFFF, 16'h0100, 2'd1, 3'b100}   // R4 pop wraps
    };

    task automatic run_op(input logic [5:0] c, input logic [15:0] sp, input logic [15:0] pc, input int l);
        int w = 0;
        @(negedge clk);
        code_i = c; sp_i = sp; pc_i = pc; lat = l; start_i = 1'b1;
        n_pcinc = 0; n_resp = 0; n_done = 0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && w < 60) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'h0100 * (i + 1) + 16'(i);
        rf[7] = 16'hFFF0;

        repeat (3) @(negedge clk);
        chk(done_o == 0, "R13 reset done", 16'(done_o), 16'h0);
        chk(mem_req_o == 0, "R13 reset req", 16'(mem_req_o), 16'h0);
        chk(pc_inc_o == 0 && sp_upd_o == 0, "R13 reset pulses", 16'({pc_inc_o, sp_upd_o}), 16'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [5:0]  c  = VEC[v][42:37];
            logic [15:0] sp = VEC[v][36:21];
            logic [15:0] pc = VEC[v][20:5];
            int          l  = int'(VEC[v][4:3]);
            logic        em = VEC[v][2], el = VEC[v][1], ex = VEC[v][0];
            logic [15:0] eea = 16'h0, ev = 16'h0, enw = mfn(pc), esp = sp;
            logic        eupd = 1'b0;
            logic [2:0]  ek;
            int          ereads;
            string       t = $sformatf("vec%0d code=%h", v, c);
            if (c < 6'h08) begin eea = 16'(c[2:0]); ev = rf[c[2:0]]; end        // R1
            else if (c < 6'h10) begin eea = rf[c[2:0]]; ev = mfn(eea); end       // R2
            else if (c < 6'h18) begin eea = enw + rf[c[2:0]]; ev = mfn(eea); end // R3
            else if (c == 6'h18) begin eea = sp; ev = mfn(eea); esp = sp + 16'd1; eupd = 1'b1; end // R4
            else if (c == 6'h19) begin eea = sp; ev = mfn(eea); end              // R5
            else if (c == 6'h1A) begin eea = sp - 16'd1; ev = mfn(eea); esp = sp - 16'd1; eupd = 1'b1; end // R6
            else if (c == 6'h1B) ev = sp;                                        // R7
            else if (c == 6'h1C) ev = pc;
            else if (c == 6'h1D) ev = ov_i;
            else if (c == 6'h1E) begin eea = enw; ev = mfn(eea); end             // R8
            else if (c == 6'h1F) ev = enw;                                       // R9
            else ev = 16'(c) - 16'h20;                                           // R10
            ek = el ? 3'd0 : em ? 3'd2 : (c < 6'h08) ? 3'd1 :
                 (c == 6'h1B) ? 3'd3 : (c == 6'h1C) ? 3'd4 : 3'd5;
            ereads = int'(ex) + ((em) ? 1 : 0);

            run_op(c, sp, pc, l);
            chk(done_o == 1, {t, " R13 done"}, 16'(done_o), 16'h1);
            chk(value_o == ev, {t, " R1-value"}, value_o, ev);
            if (em || c < 6'h08)
                chk(ea_o == eea, {t, " R2 ea"}, ea_o, eea);
            chk(is_mem_o == em, {t, " R2 is_mem"}, 16'(is_mem_o), 16'(em));
            chk(is_lit_o == el, {t, " R11 is_lit"}, 16'(is_lit_o), 16'(el));
            chk(xcyc_o == ex, {t, " R12 xcyc"}, 16'(xcyc_o), 16'(ex));
            chk(sp_upd_o == eupd, {t, " R5 sp_upd"}, 16'(sp_upd_o), 16'(eupd));
            if (eupd) chk(sp_nxt_o == esp, {t, " R6 sp_nxt"}, sp_nxt_o, esp);
            @(negedge clk);
            chk(n_pcinc == int'(ex), {t, " R12 pc_inc count"}, 16'(n_pcinc), 16'(ex));
            chk(n_resp == ereads, {t, " R9 mem reads"}, 16'(n_resp), 16'(ereads));
            chk(done_o == 0, {t, " R13 done pulse"}, 16'(done_o), 16'h0);
            chk(wr_kind_o == 3'd0, {t, " R14 no wb"}, 16'(wr_kind_o), 16'h0);
            wb_i = 1'b1; wb_data_i = 16'hBE00 + 16'(v);
            #1;
            chk(wr_kind_o == ek, {t, " R11 R14 wr_kind"}, 16'(wr_kind_o), 16'(ek));
            if (ek != 3'd0) begin
                chk(wr_data_o == wb_data_i, {t, " R14 wr_data"}, wr_data_o, wb_data_i);
                chk(wr_addr_o == ea_o, {t, " R14 wr_addr"}, wr_addr_o, ea_o);
            end
            wb_i = 1'b0;
        end

        // R13: start while busy is ignored, result holds afterwards
        @(negedge clk);
        code_i = 6'h1E; pc_i = 16'h0500; lat = 3; start_i = 1'b1;
        n_pcinc = 0; n_done = 0;
        @(negedge clk);
        code_i = 6'h00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_done == 1, "R13 busy start ignored done count", 16'(n_done), 16'h1);
        chk(value_o == mfn(mfn(16'h0500)), "R13 busy start value", value_o, mfn(mfn(16'h0500)));
        chk(n_pcinc == 1, "R12 busy pc_inc", 16'(n_pcinc), 16'h1);
        chk(ea_o == mfn(16'h0500), "R13 result holds", ea_o, mfn(16'h0500));

        // R11: literal inline value with write request stays silent
        run_op(6'h25, 16'h0, 16'h0, 0);
        @(negedge clk);
        wb_i = 1'b1; #1;
        chk(wr_kind_o == 3'd0, "R11 inline literal write dropped", 16'(wr_kind_o), 16'h0);
        chk(value_o == 16'h0005, "R10 literal 5", value_o, 16'h0005);
        wb_i = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule